// File: doc/BRIEF.md
# Double-Buffered Message Word Store

This block holds message words for an iterative hash core that walks each 512-bit block in 64 steps. It contains two memories of 16 words by 32 bits. At any time one memory serves reads for the core and the other takes the incoming block. A 32-bit input stream supplies the words, and the block generates the write addresses itself with a load counter that restarts at each block. The core's step controller gives a 4-bit word address. Each step it takes also advances a step counter.

After a full set of 64 steps the read memory is released. If the other memory by then holds a complete block, the two memories trade roles at once, so a steady stream of blocks adds no load time beyond the first block. If the next block is not complete, the trade is refused. The block then lowers its ready flag so that the core waits, and it makes the trade the cycle after the last word of the pending block arrives. A word offered when no memory is free for writing would land in the memory being read. Such a word is discarded and the error flag pulses for one cycle.

Top module: `msgblk_pingpong`

## Requirements
- R1: After reset, rd_bank is 0 (memory 1 is the read side), blk_rdy, load_done and wr_err are 0, and both memories are marked empty.
- R2: Before computation starts, the first 16 accepted words go into memory 1 (rd_bank 0) at addresses 0 to 15 in arrival order. blk_rdy rises in the cycle after the 16th word is accepted and not earlier.
- R3: rd_data shows, in the same cycle, the word at rd_addr in the memory selected by rd_bank.
- R4: While a block is being computed, incoming words fill the other memory. load_done rises in the cycle after its 16th word is accepted, and rd_bank is not changed by this.
- R5: When the 64th accepted step occurs with the other memory complete, rd_bank toggles in the next cycle, blk_rdy stays 1 and load_done returns to 0.
- R6: When the 64th accepted step occurs with the other memory incomplete, rd_bank keeps its value and blk_rdy falls. While blk_rdy is 0, step_en is ignored and does not advance the step count. One cycle after the pending block completes, rd_bank toggles and blk_rdy rises.
- R7: A word offered while the pending memory already holds a complete block is discarded, and wr_err is 1 for exactly the following cycle. Neither memory's contents change.
- R8: Words are counted only in cycles with wr_valid at 1, so idle cycles between words do not shift any address.
- R9: With each next block complete before its boundary, blk_rdy stays 1 through consecutive blocks, so the core can take a step on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | An input word is offered this cycle |
| wr_data | input | 32 | Input message word |
| step_en | input | 1 | The core takes one step this cycle |
| rd_addr | input | 4 | Word address from the core's controller |
| rd_data | output | 32 | Word read from the current read memory |
| rd_bank | output | 1 | Memory now serving reads (0 is memory 1, 1 is memory 2) |
| blk_rdy | output | 1 | Read memory holds a complete block, so the core may step |
| load_done | output | 1 | The non-read memory holds a complete next block |
| wr_err | output | 1 | One-cycle pulse after a discarded word |

## Verification
The hardest case to reach from the ports is a refused swap, followed by a stall in which step_en is ignored, followed by a late swap. The bench gets there by computing a block while feeding only five words of the next one. It then pulses step_en during the stall and completes the block afterwards. It then proves that the step count did not move by checking that the next block still holds its read memory after 63 steps and swaps on the 64th. The discard case is reached by pushing extra words once both memories are full, and then reading both blocks back.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BLK_WORDS  = 16;
    localparam int unsigned BLK_STEPS  = 64;
    localparam int unsigned N_BANKS    = 2;
    typedef logic bank_idx_t;
endpackage

// File: rtl/pp_word_bank.sv
module pp_word_bank #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pp_arbiter.sv
module pp_arbiter
    import pp_buf_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    parameter int unsigned STEPS = 64,
    localparam int unsigned AW   = $clog2(WORDS),
    localparam int unsigned SW   = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          step_en,
    output logic [1:0]    bank_we,
    output logic [AW-1:0] wr_addr,
    output bank_idx_t     rd_sel,
    output logic          blk_rdy,
    output logic          load_done,
    output logic          wr_err
);
    typedef struct packed {
        bank_idx_t     sel;
        bank_idx_t     wb;
        logic [1:0]    full;
        logic [AW-1:0] wcnt;
        logic [SW-1:0] scnt;
        logic          err;
    } arb_t;

    arb_t st_d, st_q;
    logic wr_take;
    logic step_take;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        wr_take   = wr_valid && !st_q.full[st_q.wb];
        step_take = step_en && st_q.full[st_q.sel];

        if (wr_valid && st_q.full[st_q.wb]) begin
            st_d.err = 1'b1;
        end

        if (wr_take) begin
            if (st_q.wcnt == AW'(WORDS - 1)) begin
                st_d.wcnt          = '0;
                st_d.full[st_q.wb] = 1'b1;
                st_d.wb            = ~st_q.wb;
            end else begin
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end

        if (step_take) begin
            if (st_q.scnt == SW'(STEPS - 1)) begin
                st_d.scnt           = '0;
                st_d.full[st_q.sel] = 1'b0;
                if (st_d.full[~st_q.sel]) begin
                    st_d.sel = ~st_q.sel;
                end
            end else begin
                st_d.scnt = st_q.scnt + 1'b1;
            end
        end else if (!st_q.full[st_q.sel] && st_q.full[~st_q.sel]) begin
            st_d.sel = ~st_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bank_we = '0;
        bank_we[st_q.wb] = wr_take;
    end

    assign wr_addr   = st_q.wcnt;
    assign rd_sel    = st_q.sel;
    assign blk_rdy   = st_q.full[st_q.sel];
    assign load_done = st_q.full[~st_q.sel];
    assign wr_err    = st_q.err;

    AST_ERR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && st_q.full[st_q.wb]) |=> wr_err); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !blk_rdy) |=> $stable(st_q.scnt)); // R6
    AST_SWAP_TO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_sel) |-> blk_rdy); // R5
    AST_SWAP_FREES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_sel) |-> !load_done); // R5
endmodule

// File: rtl/msgblk_pingpong.sv
module msgblk_pingpong
    import pp_buf_pkg::*;
#(
    parameter int unsigned DW    = WORD_W,
    parameter int unsigned WORDS = BLK_WORDS,
    parameter int unsigned STEPS = BLK_STEPS,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          step_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_bank,
    output logic          blk_rdy,
    output logic          load_done,
    output logic          wr_err
);
    logic [N_BANKS-1:0] bank_we;
    logic [AW-1:0]      wr_addr;
    bank_idx_t          sel;
    logic [DW-1:0]      bank_rd [N_BANKS];

    pp_arbiter #(.WORDS(WORDS), .STEPS(STEPS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .step_en   (step_en),
        .bank_we   (bank_we),
        .wr_addr   (wr_addr),
        .rd_sel    (sel),
        .blk_rdy   (blk_rdy),
        .load_done (load_done),
        .wr_err    (wr_err)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        pp_word_bank #(.WIDTH(DW), .DEPTH(WORDS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (rd_addr),
            .rdata (bank_rd[g])
        );
    end

    assign rd_data = bank_rd[sel];
    assign rd_bank = sel;

    AST_NO_READ_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we[sel] |-> !blk_rdy); // R7
endmodule

// File: tb/tb_msgblk_pingpong.sv
module tb_msgblk_pingpong;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        step_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_bank, blk_rdy, load_done, wr_err;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    msgblk_pingpong dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .step_en(step_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_bank(rd_bank), .blk_rdy(blk_rdy), .load_done(load_done), .wr_err(wr_err)
    );

    function automatic logic [31:0] word(int b, int k);
        return {16'(b + 16'h3A00), 16'(k) * 16'h0101 + 16'h0007};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(logic wv, logic [31:0] wd, logic se, logic [3:0] ra);
        wr_valid = wv; wr_data = wd; step_en = se; rd_addr = ra;
        @(negedge clk);
    endtask

    task automatic idle();
        tick(1'b0, '0, 1'b0, '0);
    endtask

    task automatic read_all(int b, string req);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #1;
            chk(req, rd_data, word(b, a));
        end
    endtask

    task automatic run_steps(int rb, int s0, int ns, int wbk, int wst, int nw);
        for (int s = s0; s < s0 + ns; s++) begin
            wr_valid = (s - s0) < nw;
            wr_data  = word(wbk, wst + s - s0);
            step_en  = 1'b1;
            rd_addr  = 4'(s % 16);
            #1;
            chk("R3", rd_data, word(rb, s % 16));
            chk("R9", blk_rdy, 1'b1);
            @(negedge clk);
        end
        wr_valid = 1'b0; step_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", rd_bank, 1'b0);
        chk("R1", blk_rdy, 1'b0);
        chk("R1", load_done, 1'b0);
        chk("R1", wr_err, 1'b0);
    endtask

    task automatic t_first_load();
        for (int k = 0; k < 16; k++) begin
            tick(1'b1, word(0, k), 1'b0, '0);
            chk("R2", blk_rdy, k == 15);
            idle();
            chk("R8", blk_rdy, k == 15);
        end
        chk("R2", rd_bank, 1'b0);
        chk("R2", load_done, 1'b0);
        read_all(0, "R2");
    endtask

    task automatic t_overlap();
        run_steps(0, 0, 16, 1, 0, 16);
        chk("R4", load_done, 1'b1);
        chk("R4", rd_bank, 1'b0);
        run_steps(0, 16, 48, 0, 0, 0);
        chk("R5", rd_bank, 1'b1);
        chk("R5", blk_rdy, 1'b1);
        chk("R5", load_done, 1'b0);
    endtask

    task automatic t_refused();
        run_steps(1, 0, 64, 2, 0, 5);
        chk("R6", rd_bank, 1'b1);
        chk("R6", blk_rdy, 1'b0);
        chk("R6", load_done, 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b0, '0, 1'b1, '0);
        chk("R6", blk_rdy, 1'b0);
        for (int k = 5; k < 16; k++) tick(1'b1, word(2, k), 1'b0, '0);
        chk("R6", load_done, 1'b1);
        chk("R6", blk_rdy, 1'b0);
        idle();
        chk("R6", rd_bank, 1'b0);
        chk("R6", blk_rdy, 1'b1);
        chk("R6", load_done, 1'b0);
        run_steps(2, 0, 63, 3, 0, 16);
        chk("R6", rd_bank, 1'b0);
        chk("R6", blk_rdy, 1'b1);
        chk("R4", load_done, 1'b1);
    endtask

    task automatic t_discard();
        tick(1'b1, 32'hDEAD_BEEF, 1'b0, '0);
        chk("R7", wr_err, 1'b1);
        tick(1'b1, 32'hFEED_F00D, 1'b0, '0);
        chk("R7", wr_err, 1'b1);
        idle();
        chk("R7", wr_err, 1'b0);
        read_all(2, "R7");
        run_steps(2, 63, 1, 0, 0, 0);
        chk("R5", rd_bank, 1'b1);
        chk("R5", blk_rdy, 1'b1);
        chk("R5", load_done, 1'b0);
        read_all(3, "R7");
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_load();
        t_overlap();
        t_refused();
        t_discard();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule